// File: doc/BRIEF.md
# Halving Tree Sum Reducer

This block keeps a bank of partial sums, one register for each logical processor slot, and reduces a chosen number of them to a single total. The reduction runs in rounds. In every round, the lower half of the active slots each add in a partner from the upper half, and the active count is then halved. When the active count is odd, slot 0 first takes in the unpaired top element, in a separate cycle, and only then is the count halved. The round boundary serves as the barrier between steps. No step reads a slot before the previous step has written it. Values are 32-bit two's-complement integers and wrap on overflow.

Software or a neighbouring block fills the slots through a single-word write port while the engine is idle. It then pulses `start` with the number of slots to combine. The engine stays busy for one cycle per odd fix-up, plus one cycle per halving, plus one finishing cycle. It pulses `done` in that finishing cycle, and the total is then available on `result`, which always shows slot 0. `steps` reports how many halving rounds the current or last run has taken.

The controller uses four named states. `ST_IDLE` accepts writes and `start`. `ST_ODDFIX` folds the top odd element into slot 0. `ST_HALVE` performs all pair additions of one round in parallel. `ST_FINISH` raises `done`. The transitions are as follows:
- idle→finish on start with an effective count of 0 or 1;
- idle→oddfix on start with an odd effective count;
- idle→halve on start with an even effective count;
- oddfix→halve, always;
- halve→oddfix when the new count is odd and above 1;
- halve→halve when the new count is even;
- halve→finish when the new count is 1;
- finish→idle, always.

Top module: `tree_reducer`

## Requirements
- R1: While idle, a write with `wr_en` high stores `wr_data` into slot `wr_idx` at the next clock edge. A write whose `wr_idx` is at or above SLOTS (128) changes no slot.
- R2: `start` in an idle cycle is accepted, and `busy` is high from the following cycle until the cycle after `done`. The effective count is `count`, limited to SLOTS.
- R3: When `done` is high, `result` equals the sum of slots 0 to n-1, as they stood when `start` was accepted, where n is the effective count.
- R4: The sums are 32 bits wide and wrap modulo 2^32 on overflow.
- R5: An effective count of 0 or 1 raises `done` in the first cycle after acceptance, and `result` is the unchanged slot 0.
- R6: The number of busy cycles, counting the `done` cycle, is one per odd fix-up plus one per halving plus one. When `done` is high, `steps` equals the number of halvings (floor of log2 n).
- R7: A `start` pulse while `busy` is high is ignored and does not change the run in progress.
- R8: A write while `busy` is high changes no slot.
- R9: A write in the same cycle as an accepted `start` is stored before the first step, and it is included in the total.
- R10: `done` is high for exactly one cycle, and `busy` is low in the cycle after it.
- R11: A `count` above SLOTS reduces exactly SLOTS slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, clears all slots |
| start | input | 1 | Begins a reduction when idle |
| count | input | 8 | Number of slots to reduce |
| wr_en | input | 1 | Slot write strobe |
| wr_idx | input | 8 | Slot index for the write |
| wr_data | input | 32 | Value to write |
| busy | output | 1 | Reduction in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Contents of slot 0 |
| steps | output | 8 | Halving rounds taken in the current or last run |

## Verification
The functions that can coincide are the slot write port and the start of a reduction. A write can land in the very cycle that `start` is accepted, and the bench drives both in one cycle and expects the written value to appear in the total. The reverse overlap is provoked as well. Writes and a second `start` are driven throughout a running reduction, including its `done` cycle. The bench then judges at the ports that the total, the step count and a follow-up single-slot run all show that these writes and the second `start` had no effect.

// File: rtl/tree_reduce_pkg.sv
package tree_reduce_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ODDFIX = 2'd1,
        ST_HALVE  = 2'd2,
        ST_FINISH = 2'd3
    } red_state_t;
endpackage

// File: rtl/reduce_ctrl.sv
module reduce_ctrl
    import tree_reduce_pkg::*;
#(
    parameter int SLOTS = 128,
    parameter int CNT_W = 8,
    parameter int IDX_W = $clog2(SLOTS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] count,
    output logic             busy,
    output logic             done,
    output logic             fix_en,
    output logic             halve_en,
    output logic [IDX_W-1:0] fix_idx,
    output logic [IDX_W-1:0] part_half,
    output logic [CNT_W-1:0] steps
);
    localparam logic [CNT_W-1:0] SLOTS_C = CNT_W'(SLOTS);

    red_state_t       state_q, state_d;
    logic [CNT_W-1:0] half_q;
    logic [CNT_W-1:0] steps_q;
    logic [CNT_W-1:0] eff_cnt;
    logic [CNT_W-1:0] next_half;
    logic             accept;

    assign eff_cnt   = (count > SLOTS_C) ? SLOTS_C : count;
    assign next_half = half_q >> 1;
    assign accept    = (state_q == ST_IDLE) && start;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    if (eff_cnt <= CNT_W'(1))
                        state_d = ST_FINISH;
                    else if (eff_cnt[0])
                        state_d = ST_ODDFIX;
                    else
                        state_d = ST_HALVE;
                end
            end
            ST_ODDFIX: state_d = ST_HALVE;
            ST_HALVE: begin
                if (next_half <= CNT_W'(1))
                    state_d = ST_FINISH;
                else if (next_half[0])
                    state_d = ST_ODDFIX;
                else
                    state_d = ST_HALVE;
            end
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // active count and round counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            half_q  <= '0;
            steps_q <= '0;
        end else if (accept) begin
            half_q  <= eff_cnt;
            steps_q <= '0;
        end else if (state_q == ST_HALVE) begin
            half_q  <= next_half;
            steps_q <= steps_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        busy      = (state_q != ST_IDLE);
        done      = (state_q == ST_FINISH);
        fix_en    = (state_q == ST_ODDFIX);
        halve_en  = (state_q == ST_HALVE);
        fix_idx   = IDX_W'(half_q - 1'b1);
        part_half = IDX_W'(next_half);
        steps     = steps_q;
    end
endmodule

// File: rtl/reduce_bank.sv
module reduce_bank #(
    parameter int SLOTS  = 128,
    parameter int DATA_W = 32,
    parameter int IDX_W  = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              fix_en,
    input  logic [IDX_W-1:0]  fix_idx,
    input  logic              halve_en,
    input  logic [IDX_W-1:0]  part_half,
    output logic [DATA_W-1:0] head
);
    localparam int PAIRS = SLOTS / 2;

    logic [DATA_W-1:0] slot_q   [SLOTS];
    logic [DATA_W-1:0] pair_sum [PAIRS];
    logic [DATA_W-1:0] fix_sum;

    assign fix_sum = slot_q[0] + slot_q[fix_idx];

    // one adder per low-half slot; partner index is only meaningful below part_half
    for (genvar g = 0; g < PAIRS; g++) begin : g_pair
        logic [IDX_W-1:0] pidx;
        assign pidx        = IDX_W'(g) + part_half;
        assign pair_sum[g] = slot_q[g] + slot_q[pidx];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < SLOTS; i++) slot_q[i] <= '0;
        end else if (halve_en) begin
            for (int i = 0; i < PAIRS; i++) begin
                if (IDX_W'(i) < part_half) slot_q[i] <= pair_sum[i];
            end
        end else if (fix_en) begin
            slot_q[0] <= fix_sum;
        end else if (wr_en) begin
            slot_q[wr_idx] <= wr_data;
        end
    end

    assign head = slot_q[0];
endmodule

// File: rtl/tree_reducer.sv
module tree_reducer #(
    parameter int SLOTS  = 128,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CNT_W-1:0]  count,
    input  logic              wr_en,
    input  logic [CNT_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] result,
    output logic [CNT_W-1:0]  steps
);
    localparam int               IDX_W   = $clog2(SLOTS);
    localparam logic [CNT_W-1:0] SLOTS_C = CNT_W'(SLOTS);

    logic             fix_en;
    logic             halve_en;
    logic [IDX_W-1:0] fix_idx;
    logic [IDX_W-1:0] part_half;
    logic             wr_ok;

    assign wr_ok = wr_en && !busy && (wr_idx < SLOTS_C);

    reduce_ctrl #(
        .SLOTS (SLOTS),
        .CNT_W (CNT_W),
        .IDX_W (IDX_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .count     (count),
        .busy      (busy),
        .done      (done),
        .fix_en    (fix_en),
        .halve_en  (halve_en),
        .fix_idx   (fix_idx),
        .part_half (part_half),
        .steps     (steps)
    );

    reduce_bank #(
        .SLOTS  (SLOTS),
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_ok),
        .wr_idx    (wr_idx[IDX_W-1:0]),
        .wr_data   (wr_data),
        .fix_en    (fix_en),
        .fix_idx   (fix_idx),
        .halve_en  (halve_en),
        .part_half (part_half),
        .head      (result)
    );
endmodule

// File: rtl/tree_reducer_chk.sv
module tree_reducer_chk #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [CNT_W-1:0]  count,
    input logic              wr_en,
    input logic              busy,
    input logic              done,
    input logic [DATA_W-1:0] result,
    input logic [CNT_W-1:0]  steps
);
    AST_START_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy); // R2

    AST_START_CLEARS_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (steps == '0)); // R6

    AST_SMALL_COUNT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && count <= CNT_W'(1)) |=> done); // R5

    AST_BUSY_ONLY_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start)); // R7

    AST_STEP_GROWTH: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (steps == $past(steps) || steps == $past(steps) + 1'b1)); // R6

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy)); // R10

    AST_IDLE_HOLDS_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !wr_en) |=> $stable(result)); // R1
endmodule

bind tree_reducer tree_reducer_chk #(
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .count  (count),
    .wr_en  (wr_en),
    .busy   (busy),
    .done   (done),
    .result (result),
    .steps  (steps)
);

// File: tb/test_tree_reducer.sv
`timescale 1ns/1ps
module test_tree_reducer;
    localparam int SLOTS = 128;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  count = '0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_idx = '0;
    logic [31:0] wr_data = '0;
    logic        busy, done;
    logic [31:0] result;
    logic [7:0]  steps;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic [31:0] mdl [SLOTS];

    always #2.5 clk = ~clk;

    tree_reducer i_tree_reducer (
        .clk(clk), .rst_n(rst_n), .start(start), .count(count),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .busy(busy), .done(done), .result(result), .steps(steps)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog: expected run end, actual %0d cycles", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic write_slot(input int idx, input logic [31:0] val);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 8'(idx); wr_data = val;
        if (idx < SLOTS && !busy) mdl[idx] = val;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic fill(input int n, input logic [31:0] base, input logic [31:0] stride);
        for (int i = 0; i < n; i++) write_slot(i, base + stride * 32'(i));
    endtask

    function automatic logic [31:0] exp_sum(input int n);
        logic [31:0] s = '0;
        int m = (n > SLOTS) ? SLOTS : n;
        if (m < 1) m = 1;
        for (int i = 0; i < m; i++) s = s + mdl[i];
        return s;
    endfunction

    function automatic int exp_rounds(input int n);
        int h = (n > SLOTS) ? SLOTS : n;
        int r = 0;
        while (h > 1) begin h = h / 2; r++; end
        return r;
    endfunction

    function automatic int exp_latency(input int n);
        int h = (n > SLOTS) ? SLOTS : n;
        int l = 0;
        while (h > 1) begin
            if (h % 2 == 1) l++;
            h = h / 2;
            l++;
        end
        return l + 1;
    endfunction

    // pulse start, wait for done; returns busy cycles up to done
    task automatic run(input int n, output int lat);
        @(negedge clk);
        start = 1'b1; count = 8'(n);
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 400) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic finish_run(input string req, input int n, input int lat);
        logic [31:0] tot = exp_sum(n);
        check({req, " total"}, result, tot);
        check("R6 steps", 32'(steps), 32'(exp_rounds(n)));
        check("R6 latency", 32'(lat), 32'(exp_latency(n)));
        check("R10 done high", 32'(done), 32'd1);
        @(negedge clk);
        check("R10 done one cycle", 32'(done), 32'd0);
        check("R10 busy drops", 32'(busy), 32'd0);
        mdl[0] = tot;
    endtask

    task automatic t_reset();
        check("R2 reset busy", 32'(busy), 32'd0);
        check("R10 reset done", 32'(done), 32'd0);
        check("R1 reset result", result, 32'd0);
    endtask

    task automatic t_hundred();
        int lat;
        fill(100, 32'd5, 32'd3);
        run(100, lat);
        finish_run("R3 n=100", 100, lat);
    endtask

    task automatic t_odd_seven();
        int lat;
        fill(7, 32'd11, 32'd100);
        run(7, lat);
        finish_run("R3 n=7", 7, lat);
    endtask

    task automatic t_wrap();
        int lat;
        fill(SLOTS, 32'hF000_0000, 32'h0123_4567);
        run(SLOTS, lat);
        finish_run("R4 wrap n=128", SLOTS, lat);
    endtask

    task automatic t_pair();
        int lat;
        write_slot(0, 32'hFFFF_FFFF);
        write_slot(1, 32'd2);
        run(2, lat);
        finish_run("R4 R6 n=2", 2, lat);
    endtask

    task automatic t_small();
        int lat;
        write_slot(0, 32'd55);
        run(1, lat);
        check("R5 count1 latency", 32'(lat), 32'd1);
        check("R5 count1 result", result, 32'd55);
        finish_run("R5 n=1", 1, lat);
        write_slot(0, 32'd77);
        run(0, lat);
        check("R5 count0 latency", 32'(lat), 32'd1);
        check("R5 count0 result", result, 32'd77);
        finish_run("R5 n=0", 0, lat);
    endtask

    task automatic t_clamp_and_oor();
        int lat;
        fill(SLOTS, 32'd1, 32'd1);
        // index beyond the bank must not alias onto a slot (R1)
        write_slot(200, 32'h4000_0000);
        write_slot(130, 32'h2000_0000);
        run(250, lat);
        check("R11 clamp steps", 32'(steps), 32'd7);
        finish_run("R1 R11 clamp", 250, lat);
    endtask

    task automatic t_busy_inputs();
        int lat;
        logic [31:0] tot;
        fill(100, 32'd9, 32'd7);
        tot = exp_sum(100);
        @(negedge clk);
        start = 1'b1; count = 8'd100;
        @(negedge clk);
        lat = 1;
        start = 1'b0;
        // during the run: writes to slot 0 and repeated start requests
        while (!done && lat < 400) begin
            wr_en = 1'b1; wr_idx = 8'd0; wr_data = 32'hDEAD_BEEF;
            start = (lat % 3 == 0); count = 8'd2;
            @(negedge clk);
            lat++;
        end
        // also in the done cycle
        wr_en = 1'b1; wr_idx = 8'd0; wr_data = 32'hBAD0_0BAD;
        start = 1'b1; count = 8'd2;
        check("R7 R8 total", result, tot);
        check("R7 steps", 32'(steps), 32'd6);
        check("R7 latency", 32'(lat), 32'(exp_latency(100)));
        @(negedge clk);
        wr_en = 1'b0; start = 1'b0;
        check("R7 no restart", 32'(busy), 32'd0);
        mdl[0] = tot;
        run(1, lat);
        check("R8 slot0 untouched", result, tot);
        @(negedge clk);
    endtask

    task automatic t_same_cycle();
        int lat;
        write_slot(0, 32'd1);
        write_slot(1, 32'd2);
        write_slot(2, 32'd3);
        write_slot(3, 32'd4);
        @(negedge clk);
        start = 1'b1; count = 8'd4;
        wr_en = 1'b1; wr_idx = 8'd3; wr_data = 32'd100;
        @(negedge clk);
        start = 1'b0; wr_en = 1'b0;
        lat = 1;
        while (!done && lat < 400) begin
            @(negedge clk);
            lat++;
        end
        check("R9 same-cycle write", result, 32'd106);
        check("R9 latency", 32'(lat), 32'd3);
        @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < SLOTS; i++) mdl[i] = '0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_hundred();
        t_odd_seven();
        t_wrap();
        t_pair();
        t_small();
        t_clamp_and_oor();
        t_busy_inputs();
        t_same_cycle();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule